// File: doc/BRIEF.md
# Skip-Pattern Sequencer with Call Freeze

This block decides, instruction by instruction, whether a processor core should drop or jump over an upcoming instruction. A skip instruction loads a pattern word in which each set bit marks one upcoming instruction for skipping. The sequencer then works through that word as instructions execute. It can work in one of two ways. In cancel mode, the instruction now at the head of the pipeline is turned into a no-op. In fast mode, the block gives a PC advance that steps over a whole run of marked instructions at once, so those instructions are never fetched.

Subroutines called from inside a skip sequence run in full. Each executed call raises a small nesting counter, and each return lowers it. While the counter is nonzero, the pattern does not move. Interrupt service works the same way: a flag is set on interrupt entry and cleared on interrupt exit, and skipping stays paused while the flag is set. The remaining pattern bits pick up where they stopped once both the counter and the flag are clear.

The strobes are sampled on every clock edge. Each strobe stands for one instruction slot: a skip load on `load_valid`, or any other instruction on `instr_valid`. The two are never raised together. `cancel` and `pc_adv` belong to the slot presented in the same cycle.

Top module: `skip_seq`

## Requirements
- R1: After reset the pattern is empty, the nesting depth is 0 and the interrupt flag is clear, so `busy`=0, `suspended`=0, `cancel`=0, `pc_adv`=1 and `freeze_depth`=0.
- R2: In cancel mode (`load_fast`=0 at load), pattern bit 0 belongs to the instruction presented with `instr_valid`. That instruction has `cancel` equal to bit 0, and the pattern then shifts right by one. The loading slot itself is never cancelled.
- R3: In fast mode (`load_fast`=1), pattern bit 0 belongs to the instruction after the current slot. The current slot, including the loading slot, gets `pc_adv` = 1 + T, where T is the number of consecutive ones from bit 0 and T saturates at PAT_W for an all-ones word. The pattern then shifts right by `pc_adv`, and an all-ones word becomes empty.
- R4: A skip load sets `freeze_depth` to 0.
- R5: An executed (not cancelled) call raises `freeze_depth` by one, saturating at 2^FRZ_W-1. An executed return lowers it by one, saturating at 0.
- R6: While `freeze_depth` is nonzero or the interrupt flag is set, `suspended`=1. In that state no slot is cancelled, `pc_adv` is 1 and the pattern does not move.
- R7: In cancel mode, a call whose pattern bit is 1 uses up exactly one pattern bit and leaves `freeze_depth` unchanged. The same holds for a return whose pattern bit is 1.
- R8: `irq_enter` sets the interrupt flag from the next cycle, and `irq_exit` clears it (entry wins if both are raised). The flag does not change `freeze_depth`. The pattern bits left at entry are used again after exit.
- R9: When the pattern is empty, `busy`=0, `cancel`=0 and `pc_adv`=1.
- R10: In fast mode `cancel` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Skip instruction executes this cycle and loads a pattern |
| load_fast | input | 1 | Mode taken at load: 1 selects fast mode, 0 selects cancel mode |
| load_pattern | input | PAT_W | Pattern word, one bit per upcoming instruction |
| instr_valid | input | 1 | A non-skip instruction is at the head of the pipeline this cycle |
| is_call | input | 1 | The slot on `instr_valid` is a call |
| is_ret | input | 1 | The slot on `instr_valid` is a return |
| irq_enter | input | 1 | Interrupt service begins |
| irq_exit | input | 1 | Interrupt service returns |
| cancel | output | 1 | Turn the current slot into a no-op |
| pc_adv | output | clog2(PAT_W+2) | Instruction count to add to the PC after the current slot |
| busy | output | 1 | Pattern still holds set bits |
| suspended | output | 1 | Skipping is paused by call nesting or interrupt service |
| freeze_depth | output | FRZ_W | Current call nesting depth |

## Verification
The hardest state to reach from the ports combines a deep call nest with a pattern whose next bit is 1. Reaching it needs a cancelled call first, then an executed call, then enough nested calls to hit the depth ceiling, and then more returns than calls. Only after all of that does the pattern resume. The bench drives exactly that sequence on a pattern chosen so that each step lands on a known bit. It also interleaves interrupt entry and exit with calls in fast mode. Pattern walks in both modes cover single bits at every position, alternating words, the all-ones word and a set of generated words. A model in the bench predicts every output in every cycle.

// File: rtl/skip_pkg.sv
package skip_pkg;

    typedef enum logic {
        MODE_CANCEL = 1'b0,
        MODE_FAST   = 1'b1
    } skip_mode_e;

endpackage

// File: rtl/skip_run_len.sv
module skip_run_len #(
    parameter int PAT_W = 32,
    localparam int CNT_W = $clog2(PAT_W + 1)
) (
    input  logic [PAT_W-1:0] pat,
    output logic [CNT_W-1:0] len
);
    // number of consecutive ones starting at bit 0
    always_comb begin
        logic stop;
        stop = 1'b0;
        len  = '0;
        for (int i = 0; i < PAT_W; i++) begin
            if (!stop && pat[i]) begin
                len = len + CNT_W'(1);
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/skip_freeze_ctr.sv
module skip_freeze_ctr #(
    parameter int FRZ_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [FRZ_W-1:0] depth
);
    localparam logic [FRZ_W-1:0] TOP = '1;

    logic [FRZ_W-1:0] depth_d, depth_q;

    always_comb begin
        depth_d = depth_q;
        if (clr) begin
            depth_d = '0;
        end else if (inc && !dec && depth_q != TOP) begin
            depth_d = depth_q + FRZ_W'(1);
        end else if (dec && !inc && depth_q != '0) begin
            depth_d = depth_q - FRZ_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) depth_q <= '0;
        else        depth_q <= depth_d;
    end

    assign depth = depth_q;
endmodule

// File: rtl/skip_seq.sv
module skip_seq
    import skip_pkg::*;
#(
    parameter int PAT_W = 32,
    parameter int FRZ_W = 3,
    localparam int ADV_W = $clog2(PAT_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_valid,
    input  logic             load_fast,
    input  logic [PAT_W-1:0] load_pattern,
    input  logic             instr_valid,
    input  logic             is_call,
    input  logic             is_ret,
    input  logic             irq_enter,
    input  logic             irq_exit,
    output logic             cancel,
    output logic [ADV_W-1:0] pc_adv,
    output logic             busy,
    output logic             suspended,
    output logic [FRZ_W-1:0] freeze_depth
);
    localparam int CNT_W = $clog2(PAT_W + 1);

    typedef struct packed {
        logic [PAT_W-1:0] pat;
        skip_mode_e       mode;
        logic             isr;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [FRZ_W-1:0] depth;
    logic             hold;
    logic [PAT_W-1:0] src_pat;
    logic [CNT_W-1:0] run_len;
    logic [ADV_W-1:0] adv_val;
    logic [PAT_W-1:0] jumped;
    logic             fast_src;
    logic             adv_fast;
    logic             cancel_c;
    logic [ADV_W-1:0] adv_c;
    logic             ctr_inc, ctr_dec;
    logic [PAT_W-1:0] pat_q;
    logic             fast_q;

    assign hold     = (depth != '0) || state_q.isr;
    assign src_pat  = load_valid ? load_pattern : state_q.pat;
    assign fast_src = load_valid ? load_fast : (state_q.mode == MODE_FAST);
    assign adv_fast = fast_src && (load_valid ? !state_q.isr : (instr_valid && !hold));

    skip_run_len #(.PAT_W(PAT_W)) u_run (
        .pat (src_pat),
        .len (run_len)
    );

    assign adv_val = ADV_W'(run_len) + ADV_W'(1);

    always_comb begin
        if (int'(adv_val) >= PAT_W) jumped = '0;
        else                        jumped = src_pat >> adv_val;
    end

    always_comb begin
        state_d  = state_q;
        cancel_c = 1'b0;
        adv_c    = ADV_W'(1);
        if (load_valid) begin
            state_d.mode = load_fast ? MODE_FAST : MODE_CANCEL;
            state_d.pat  = adv_fast ? jumped : load_pattern;
        end else if (instr_valid && !hold) begin
            if (state_q.mode == MODE_FAST) begin
                state_d.pat = jumped;
            end else begin
                cancel_c    = state_q.pat[0];
                state_d.pat = state_q.pat >> 1;
            end
        end
        if (adv_fast) adv_c = adv_val;
        if (irq_enter)     state_d.isr = 1'b1;
        else if (irq_exit) state_d.isr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pat  <= '0;
            state_q.mode <= MODE_CANCEL;
            state_q.isr  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctr_inc = instr_valid && !load_valid && is_call && !cancel_c;
    assign ctr_dec = instr_valid && !load_valid && is_ret && !cancel_c;

    skip_freeze_ctr #(.FRZ_W(FRZ_W)) u_frz (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_valid),
        .inc   (ctr_inc),
        .dec   (ctr_dec),
        .depth (depth)
    );

    assign pat_q        = state_q.pat;
    assign fast_q       = (state_q.mode == MODE_FAST);
    assign cancel       = cancel_c;
    assign pc_adv       = adc_or_one(adv_c);
    assign busy         = (state_q.pat != '0);
    assign suspended    = hold;
    assign freeze_depth = depth;

    function automatic logic [ADV_W-1:0] adc_or_one(input logic [ADV_W-1:0] v);
        return (v == '0) ? ADV_W'(1) : v;
    endfunction
endmodule

// File: rtl/skip_seq_chk.sv
module skip_seq_chk #(
    parameter int PAT_W = 32,
    parameter int FRZ_W = 3,
    localparam int ADV_W = $clog2(PAT_W + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_valid,
    input logic             instr_valid,
    input logic             is_call,
    input logic             is_ret,
    input logic             irq_enter,
    input logic             cancel,
    input logic [ADV_W-1:0] pc_adv,
    input logic             busy,
    input logic             suspended,
    input logic [FRZ_W-1:0] freeze_depth,
    input logic [PAT_W-1:0] pat_q,
    input logic             fast_q
);
    localparam logic [FRZ_W-1:0] TOP = '1;

    // R6
    hold_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !load_valid) |-> (!cancel && pc_adv == ADV_W'(1)));

    // R6
    hold_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !load_valid) |=> (pat_q == $past(pat_q)));

    // R10
    fast_no_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_q |-> !cancel);

    // R4
    load_clears_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> (freeze_depth == '0));

    // R5
    call_raises_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !load_valid && is_call && !is_ret && !cancel && freeze_depth != TOP)
        |=> (freeze_depth == $past(freeze_depth) + FRZ_W'(1)));

    // R9
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_valid) |-> (!cancel && pc_adv == ADV_W'(1)));

    // R8
    irq_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> suspended);

    // R2
    cancel_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !load_valid && !suspended && !fast_q) |=> (pat_q == ($past(pat_q) >> 1)));
endmodule

bind skip_seq skip_seq_chk #(.PAT_W(PAT_W), .FRZ_W(FRZ_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_valid   (load_valid),
    .instr_valid  (instr_valid),
    .is_call      (is_call),
    .is_ret       (is_ret),
    .irq_enter    (irq_enter),
    .cancel       (cancel),
    .pc_adv       (pc_adv),
    .busy         (busy),
    .suspended    (suspended),
    .freeze_depth (freeze_depth),
    .pat_q        (pat_q),
    .fast_q       (fast_q)
);

// File: tb/skip_seq_test.sv
module skip_seq_test;
    localparam int PAT_W = 32;
    localparam int FRZ_W = 3;
    localparam int ADV_W = $clog2(PAT_W + 2);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_valid = 1'b0, load_fast = 1'b0;
    logic [PAT_W-1:0] load_pattern = '0;
    logic             instr_valid = 1'b0, is_call = 1'b0, is_ret = 1'b0;
    logic             irq_enter = 1'b0, irq_exit = 1'b0;
    logic             cancel, busy, suspended;
    logic [ADV_W-1:0] pc_adv;
    logic [FRZ_W-1:0] freeze_depth;

    always #2.5 clk = ~clk;

    skip_seq #(.PAT_W(PAT_W), .FRZ_W(FRZ_W)) uut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_fast(load_fast),
        .load_pattern(load_pattern), .instr_valid(instr_valid), .is_call(is_call),
        .is_ret(is_ret), .irq_enter(irq_enter), .irq_exit(irq_exit), .cancel(cancel),
        .pc_adv(pc_adv), .busy(busy), .suspended(suspended), .freeze_depth(freeze_depth)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model
    logic [PAT_W-1:0] m_pat = '0;
    logic             m_fast = 1'b0;
    int               m_frz = 0;
    logic             m_isr = 1'b0;
    localparam int    FRZ_TOP = (1 << FRZ_W) - 1;

    function automatic int ones_run(input logic [PAT_W-1:0] p);
        int n = 0;
        while (n < PAT_W && p[n]) n++;
        return n;
    endfunction

    function automatic logic [PAT_W-1:0] drop(input logic [PAT_W-1:0] p, input int k);
        return (k >= PAT_W) ? '0 : (p >> k);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic ld, input logic ldf, input logic [PAT_W-1:0] ldp,
                        input logic iv, input logic c, input logic r,
                        input logic ie, input logic ix, input string tag);
        int  e_adv;
        bit  e_cancel;
        bit  susp;
        int  t;
        @(negedge clk);
        load_valid = ld; load_fast = ldf; load_pattern = ldp;
        instr_valid = iv; is_call = c; is_ret = r; irq_enter = ie; irq_exit = ix;
        susp = (m_frz != 0) || m_isr;
        e_adv = 1;
        e_cancel = 1'b0;
        #1;
        chk(tag, "busy", int'(busy), int'(m_pat != '0));
        chk(tag, "suspended", int'(suspended), int'(susp));
        chk(tag, "depth", int'(freeze_depth), m_frz);
        if (ld) begin
            if (ldf && !m_isr) begin
                t = ones_run(ldp);
                e_adv = t + 1;
                m_pat = drop(ldp, t + 1);
            end else begin
                m_pat = ldp;
            end
            m_fast = ldf;
            m_frz = 0;
        end else if (iv && !susp) begin
            if (m_fast) begin
                t = ones_run(m_pat);
                e_adv = t + 1;
                m_pat = drop(m_pat, t + 1);
            end else begin
                e_cancel = m_pat[0];
                m_pat = m_pat >> 1;
            end
        end
        chk(tag, "cancel", int'(cancel), int'(e_cancel));
        chk(tag, "pc_adv", int'(pc_adv), e_adv);
        if (iv && !ld && !e_cancel) begin
            if (c && !r && m_frz < FRZ_TOP) m_frz++;
            if (r && !c && m_frz > 0) m_frz--;
        end
        if (ie) m_isr = 1'b1;
        else if (ix) m_isr = 1'b0;
    endtask

    task automatic idle_ops(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, '0, 1, 0, 0, 0, 0, tag);
    endtask

    function automatic logic [PAT_W-1:0] pick(input int k);
        logic [31:0] x;
        if (k < PAT_W) return PAT_W'(1) << k;
        case (k - PAT_W)
            0: return '1;
            1: return {(PAT_W/2){2'b01}};
            2: return {(PAT_W/2){2'b10}};
            3: return ~(PAT_W'(1) << (PAT_W - 1));
            default: begin
                x = 32'h1234_5678;
                for (int j = 0; j < k; j++) x = x * 32'd1103515245 + 32'd12345;
                return PAT_W'(x);
            end
        endcase
    endfunction

    localparam int NPAT = PAT_W + 24;

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports
        step(0, 0, '0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, '0, 1, 0, 0, 0, 0, "R9");

        // R2: cancel mode walks
        for (int k = 0; k < NPAT; k++) begin
            step(1, 0, pick(k), 0, 0, 0, 0, 0, "R2");
            idle_ops(PAT_W + 1, "R2");
        end

        // R3 / R10: fast mode walks
        for (int k = 0; k < NPAT; k++) begin
            step(1, 1, pick(k), 0, 0, 0, 0, 0, "R3");
            idle_ops(PAT_W + 1, "R10");
        end

        // R7 then R5 then R6: cancelled call, executed call, nesting past the ceiling
        step(1, 0, 32'hF0F0_F0F2, 0, 0, 0, 0, 0, "R2");
        step(0, 0, '0, 1, 0, 0, 0, 0, "R2");        // bit0=0 executes
        step(0, 0, '0, 1, 1, 0, 0, 0, "R7");        // bit1=1 call cancelled
        step(0, 0, '0, 1, 1, 0, 0, 0, "R5");        // bit2=0 call executes
        for (int i = 0; i < FRZ_TOP + 2; i++) step(0, 0, '0, 1, 1, 0, 0, 0, "R5");
        idle_ops(4, "R6");
        for (int i = 0; i < FRZ_TOP + 3; i++) step(0, 0, '0, 1, 0, 1, 0, 0, "R5");
        idle_ops(8, "R2");
        // R7: cancelled return does not lower depth
        step(1, 0, 32'h0000_0005, 0, 0, 0, 0, 0, "R7");
        step(0, 0, '0, 1, 1, 0, 0, 0, "R7");        // bit0=1 call cancelled
        step(0, 0, '0, 1, 1, 0, 0, 0, "R5");        // bit1=0 call executes
        step(0, 0, '0, 1, 0, 1, 0, 0, "R5");
        step(0, 0, '0, 1, 0, 1, 0, 0, "R7");        // bit2=1 return cancelled
        idle_ops(3, "R9");

        // R4: load while nested
        step(1, 0, 32'h0000_0000, 0, 0, 0, 0, 0, "R4");
        step(0, 0, '0, 1, 1, 0, 0, 0, "R5");
        step(0, 0, '0, 1, 1, 0, 0, 0, "R5");
        step(1, 1, 32'h0000_0036, 0, 0, 0, 0, 0, "R4");
        idle_ops(5, "R4");

        // R8: interrupt in fast mode, calls inside the handler
        step(1, 1, 32'h0000_B6B6, 0, 0, 0, 0, 0, "R3");
        step(0, 0, '0, 1, 0, 0, 1, 0, "R8");
        idle_ops(3, "R8");
        step(0, 0, '0, 1, 1, 0, 0, 0, "R8");
        idle_ops(2, "R8");
        step(0, 0, '0, 1, 0, 1, 0, 1, "R8");
        idle_ops(10, "R8");
        // R8: interrupt in cancel mode with entry and exit together
        step(1, 0, 32'h0000_00FF, 0, 0, 0, 0, 0, "R2");
        step(0, 0, '0, 1, 0, 0, 0, 0, "R2");
        step(0, 0, '0, 0, 0, 0, 1, 1, "R8");
        idle_ops(3, "R8");
        step(0, 0, '0, 0, 0, 0, 0, 1, "R8");
        idle_ops(9, "R9");
        // R8: load inside handler holds the whole word
        step(0, 0, '0, 0, 0, 0, 1, 0, "R8");
        step(1, 1, 32'h0000_0007, 0, 0, 0, 0, 0, "R8");
        idle_ops(2, "R8");
        step(0, 0, '0, 0, 0, 0, 0, 1, "R8");
        idle_ops(3, "R3");

        step(0, 0, '0, 0, 0, 0, 0, 0, "R9");
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule